// File: doc/BRIEF.md
# Two-Beat Vector Pipe Issue Scheduler

This block is the in-order issue controller in front of four single-lane execution pipes: control, load/store, integer and float/multiply. A 128-bit vector operation runs as two 64-bit halves, or beats, on one pipe in two back-to-back cycles. The scheduler takes one operation per cycle from a valid/ready handshake. Each operation carries a pipe-class code and an opaque ID. The scheduler decides which pipe starts the operation's first beat, and it publishes the occupancy of every pipe as registered state.

When successive operations target different pipes, the first beat of the newer one runs alongside the second beat of the older one. A second operation for the same pipe waits until both beats of the first have run. Lane moves can go to either the integer or the float pipe. Scalar floating-point work holds the float pipe for one cycle only.

The block deals with operations as tokens. It has no datapath and no hazard tracking.

Top module: `vec_beat_sched`

## Requirements
- R1: While `rst` is high at a clock edge, every bit of `pipe_busy` and `pipe_last` is 0 in the following cycle.
- R2: A two-beat operation accepted at an edge (`in_valid && in_ready`) shows on its pipe in the next cycle with busy=1, beat index 0 and its ID. In the cycle after that, it shows busy=1, beat index 1 and the same ID. The pipe is then idle unless a new operation has started on it.
- R3: An operation whose pipe differs from that of its predecessor is accepted at the edge straight after the predecessor's. Its beat 0 therefore coincides with the predecessor's beat 1. The sequence load/store, integer, float/multiply, load/store keeps some pipe busy for exactly 5 cycles.
- R4: While a pipe is showing beat 0 of a two-beat operation, it cannot take a new operation, and `in_ready` is low for a head operation aimed at that pipe. The sequence load/store, load/store, integer, load/store keeps some pipe busy for exactly 6 cycles.
- R5: Issue is strictly in order. `in_ready` depends only on the current head operation. A stalled head keeps `in_ready` low until its pipe frees.
- R6: Class 4 (integer-or-float) goes to the integer pipe when that pipe can take it. Otherwise it goes to the float pipe when that pipe can take it. Otherwise it stalls.
- R7: Class 5 (scalar float) holds the float pipe for one cycle only, at beat index 0. The float pipe can take a new operation at the very next edge.
- R8: `pipe_last[p]` is 1 exactly in the cycle that shows an operation's final beat: beat 1 of a two-beat operation, or the only beat of a scalar-float operation.
- R9: While `flush` is high, `in_ready` is 1 and the offered operation is discarded, so no pipe starts.
- R10: Class codes 6 and 7 are consumed (`in_ready`=1) and start no pipe.
- R11: At most one operation starts per cycle, so at most one pipe shows beat index 0 at a time.
- R12: Class codes 0 to 3 select the pipe with the same index. That index is also the bit position in `pipe_busy`, `pipe_beat` and `pipe_last`, and the slot in `pipe_id`: 0 control, 1 load/store, 2 integer, 3 float/multiply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard the offered operation |
| in_valid | input | 1 | Head operation present |
| in_ready | output | 1 | Head operation accepted at this edge |
| in_class | input | 3 | Pipe-class code of the head operation |
| in_id | input | ID_W | Opaque ID of the head operation |
| pipe_busy | output | NPIPE | Pipe runs a beat this cycle |
| pipe_beat | output | NPIPE | Beat index running on each pipe |
| pipe_last | output | NPIPE | Final beat of an operation runs this cycle |
| pipe_id | output | NPIPE*ID_W | ID on each pipe, pipe p at bits [p*ID_W +: ID_W] |

## Verification
The embedded properties check the following on every cycle:
- reset clears all occupancy;
- a pipe starts only when it is free;
- beat 0 of a two-beat operation is always followed by beat 1 with an unchanged ID;
- a flush never starts a pipe;
- no more than one pipe is ever at beat 0.

Other behaviours need the bench's scenarios, which compare the outputs against a behavioural reference every cycle:
- the choice between integer and float for class 4;
- the 5- and 6-cycle spans of the overlapping and conflicting sequences;
- the one-cycle scalar-float occupancy;
- the handling of the undefined class codes.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
  localparam int NPIPE    = 4;
  localparam int PIPE_CTL = 0;
  localparam int PIPE_LS  = 1;
  localparam int PIPE_INT = 2;
  localparam int PIPE_FP  = 3;

  localparam logic [2:0] OP_CTL  = 3'd0;
  localparam logic [2:0] OP_LS   = 3'd1;
  localparam logic [2:0] OP_INT  = 3'd2;
  localparam logic [2:0] OP_FMUL = 3'd3;
  localparam logic [2:0] OP_IORF = 3'd4;
  localparam logic [2:0] OP_SFP  = 3'd5;
endpackage

// File: rtl/vbs_issue_sel.sv
module vbs_issue_sel
  import vbs_pkg::*;
(
  input  logic             in_valid,
  input  logic             flush,
  input  logic [2:0]       in_class,
  input  logic [NPIPE-1:0] take,
  output logic             in_ready,
  output logic [NPIPE-1:0] start,
  output logic             single
);
  logic [NPIPE-1:0] want;
  logic             drop;
  logic             ok;

  always_comb begin
    want   = '0;
    single = 1'b0;
    drop   = 1'b0;
    unique case (in_class)
      OP_CTL, OP_LS, OP_INT, OP_FMUL: want[in_class[1:0]] = 1'b1;
      OP_IORF: begin
        if (take[PIPE_INT]) want[PIPE_INT] = 1'b1;
        else                want[PIPE_FP]  = 1'b1;
      end
      OP_SFP: begin
        want[PIPE_FP] = 1'b1;
        single        = 1'b1;
      end
      default: drop = 1'b1;
    endcase
    ok       = |(want & take);
    in_ready = flush | drop | ok;
    start    = (in_valid && !flush && ok) ? want : '0;
  end
endmodule

// File: rtl/vbs_pipe_slot.sv
module vbs_pipe_slot #(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            start_single,
  input  logic [ID_W-1:0] start_id,
  output logic            take,
  output logic            busy,
  output logic            beat,
  output logic            last,
  output logic [ID_W-1:0] id
);
  logic single_q;

  assign last = busy & (beat | single_q);
  assign take = ~busy | last;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      beat     <= 1'b0;
      single_q <= 1'b0;
      id       <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      beat     <= 1'b0;
      single_q <= start_single;
      id       <= start_id;
    end else if (busy && !last) begin
      beat <= 1'b1;
    end else begin
      busy <= 1'b0;
    end
  end

  // R4
  take_when_free_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> take);

  // R2
  second_beat_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !beat && !single_q) |=> (busy && beat && $stable(id)));
endmodule

// File: rtl/vec_beat_sched.sv
module vec_beat_sched
  import vbs_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  flush,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [2:0]            in_class,
  input  logic [ID_W-1:0]       in_id,
  output logic [NPIPE-1:0]      pipe_busy,
  output logic [NPIPE-1:0]      pipe_beat,
  output logic [NPIPE-1:0]      pipe_last,
  output logic [NPIPE*ID_W-1:0] pipe_id
);
  logic [NPIPE-1:0] take_vec;
  logic [NPIPE-1:0] start_vec;
  logic             single;

  vbs_issue_sel u_sel (
    .in_valid (in_valid),
    .flush    (flush),
    .in_class (in_class),
    .take     (take_vec),
    .in_ready (in_ready),
    .start    (start_vec),
    .single   (single)
  );

  for (genvar p = 0; p < NPIPE; p++) begin : g_pipe
    vbs_pipe_slot #(.ID_W(ID_W)) u_slot (
      .clk          (clk),
      .rst          (rst),
      .start        (start_vec[p]),
      .start_single (single),
      .start_id     (in_id),
      .take         (take_vec[p]),
      .busy         (pipe_busy[p]),
      .beat         (pipe_beat[p]),
      .last         (pipe_last[p]),
      .id           (pipe_id[p*ID_W +: ID_W])
    );
  end

  // R1
  rst_clears_chk: assert property (@(posedge clk)
    rst |=> (pipe_busy == '0 && pipe_last == '0));

  // R9
  flush_no_start_chk: assert property (@(posedge clk) disable iff (rst)
    flush |-> (start_vec == '0));

  // R11
  one_start_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(start_vec));

  // R11
  one_first_beat_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pipe_busy & ~pipe_beat));
endmodule

// File: tb/vec_beat_sched_bench.sv
`timescale 1ns/1ps
module vec_beat_sched_bench;
  localparam int ID_W = 4;
  localparam int NP   = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, flush = 1'b0, in_valid = 1'b0, in_ready;
  logic [2:0] in_class = '0;
  logic [ID_W-1:0] in_id = '0;
  logic [NP-1:0] pipe_busy, pipe_beat, pipe_last;
  logic [NP*ID_W-1:0] pipe_id;

  vec_beat_sched #(.ID_W(ID_W)) u_vec_beat_sched (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
    .in_class(in_class), .in_id(in_id), .pipe_busy(pipe_busy), .pipe_beat(pipe_beat),
    .pipe_last(pipe_last), .pipe_id(pipe_id)
  );

  int nchk = 0, nerr = 0, cyc = 0, span = 0;
  int m_rem[NP], m_beat[NP], m_id[NP];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pick_pipe(input logic v, input logic f, input logic [2:0] c);
    if (!v || f) return -1;
    case (c)
      3'd0, 3'd1, 3'd2, 3'd3: return (m_rem[c] <= 1) ? int'(c) : -1;
      3'd4: begin
        if (m_rem[2] <= 1) return 2;
        if (m_rem[3] <= 1) return 3;
        return -1;
      end
      3'd5: return (m_rem[3] <= 1) ? 3 : -1;
      default: return -1;
    endcase
  endfunction

  function automatic bit model_ready();
    if (flush || in_class >= 3'd6) return 1'b1;
    return pick_pipe(1'b1, 1'b0, in_class) >= 0;
  endfunction

  always @(posedge clk) begin : mdl
    int p;
    if (rst) begin
      for (int q = 0; q < NP; q++) begin m_rem[q] = 0; m_beat[q] = 0; m_id[q] = 0; end
    end else begin
      p = pick_pipe(in_valid, flush, in_class);
      for (int q = 0; q < NP; q++) begin
        if (q == p) begin
          m_rem[q] = (in_class == 3'd5) ? 1 : 2;
          m_beat[q] = 0;
          m_id[q] = int'(in_id);
        end else if (m_rem[q] > 0) begin
          m_rem[q]--;
          m_beat[q] = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (!rst) begin
      for (int q = 0; q < NP; q++) begin
        chk(pipe_busy[q] == (m_rem[q] > 0), "R12 busy", pipe_busy[q], m_rem[q] > 0);
        if (m_rem[q] > 0) begin
          chk(pipe_beat[q] == m_beat[q][0], "R2 beat", pipe_beat[q], m_beat[q]);
          chk(int'(pipe_id[q*ID_W +: ID_W]) == m_id[q], "R2 id",
              pipe_id[q*ID_W +: ID_W], m_id[q]);
        end
        chk(pipe_last[q] == (m_rem[q] == 1), "R8 last", pipe_last[q], m_rem[q] == 1);
      end
      if (in_valid) chk(in_ready == model_ready(), "R5 ready", in_ready, model_ready());
      chk($countones(pipe_busy & ~pipe_beat) <= 1, "R11 one first beat",
          $countones(pipe_busy & ~pipe_beat), 1);
      if (|pipe_busy) span++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic send(input logic [2:0] c, input int id);
    @(negedge clk);
    in_valid = 1'b1; in_class = c; in_id = ID_W'(id);
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    #1;
  endtask

  task automatic wait_idle();
    while (|pipe_busy) begin @(negedge clk); #1; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(pipe_busy == '0, "R1 busy after reset", pipe_busy, 0);
    chk(pipe_last == '0, "R1 last after reset", pipe_last, 0);
    @(negedge clk); rst = 1'b0;

    // R3 overlapping sequence
    @(negedge clk); span = 0;
    send(3'd1, 1); send(3'd2, 2); send(3'd3, 3); send(3'd1, 4);
    idle(); wait_idle();
    chk(span == 5, "R3 span", span, 5);

    // R4 same-pipe conflict
    @(negedge clk); span = 0;
    send(3'd1, 5); send(3'd1, 6); send(3'd2, 7); send(3'd1, 8);
    idle(); wait_idle();
    chk(span == 6, "R4 span", span, 6);

    // R2 beat sequence on the integer pipe
    send(3'd2, 9); idle();
    chk(pipe_busy[2] && !pipe_beat[2] && pipe_id[8 +: 4] == 4'd9, "R2 beat0", pipe_beat[2], 0);
    @(negedge clk); #1;
    chk(pipe_busy[2] && pipe_beat[2] && pipe_last[2] && pipe_id[8 +: 4] == 4'd9,
        "R2 beat1", pipe_beat[2], 1);
    @(negedge clk); #1;
    chk(!pipe_busy[2], "R2 idle after", pipe_busy[2], 0);

    // R6 integer-or-float routing
    send(3'd2, 10); send(3'd4, 11); idle();
    chk(pipe_busy[3] && !pipe_beat[3] && pipe_id[12 +: 4] == 4'd11, "R6 to float",
        pipe_id[12 +: 4], 11);
    wait_idle();
    send(3'd4, 12); idle();
    chk(pipe_busy[2] && !pipe_busy[3] && pipe_id[8 +: 4] == 4'd12, "R6 to integer",
        pipe_id[8 +: 4], 12);
    wait_idle();

    // R7 scalar float back to back
    send(3'd5, 13); send(3'd5, 14); idle();
    chk(pipe_busy[3] && !pipe_beat[3] && pipe_last[3] && pipe_id[12 +: 4] == 4'd14,
        "R7 single beat", pipe_id[12 +: 4], 14);
    @(negedge clk); #1;
    chk(!pipe_busy[3], "R7 float freed", pipe_busy[3], 0);

    // R9 flush
    send(3'd2, 15);
    @(negedge clk);
    flush = 1'b1; in_valid = 1'b1; in_class = 3'd0; in_id = 4'd6;
    #1;
    chk(in_ready == 1'b1, "R9 ready under flush", in_ready, 1);
    @(negedge clk);
    flush = 1'b0; in_valid = 1'b0;
    #1;
    chk(!pipe_busy[0], "R9 nothing started", pipe_busy[0], 0);
    wait_idle();

    // R10 undefined class codes
    @(negedge clk);
    in_valid = 1'b1; in_class = 3'd7; in_id = 4'd3;
    #1;
    chk(in_ready == 1'b1, "R10 consumed", in_ready, 1);
    idle();
    chk(pipe_busy == '0, "R10 no pipe", pipe_busy, 0);

    // R5 stalled head
    send(3'd1, 1);
    @(negedge clk);
    in_valid = 1'b1; in_class = 3'd1; in_id = 4'd2;
    #1;
    chk(!in_ready, "R5 head stalls", in_ready, 0);
    @(negedge clk); #1;
    chk(in_ready, "R5 head released", in_ready, 1);
    @(posedge clk);
    idle(); wait_idle();

    // mixed traffic against the reference model
    for (int i = 0; i < 300; i++) send(3'((i * 5 + i / 4) % 8), i % 16);
    idle(); wait_idle();

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule